// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog for a simple peripheral register bus. A 16-bit counter counts down on ticks taken from the system clock through a selectable prescaler. Software has to restart it before it runs out. When it does run out, the block can raise any mix of three actions: a one-cycle internal reset pulse, a one-cycle interrupt pulse, and an active-low external overflow output that is stretched over a fixed number of clock cycles. After an overflow the counter reloads and keeps running.

The reload value is only partly programmable. Its top nibble comes from a configuration field and its low twelve bits are always ones. A write to the mode, clock or restart register takes effect only when the upper half of the same write carries the correct access key. A sticky status flag records each overflow until software reads the status register. A global run bit in the mode register holds the counter at its reload value while it is clear.

Top module: `wdog_keyed`

## Requirements
- R1: The counter is 16 bits wide and decrements by one per prescaler tick. Its reload value is {nibble, 12'hFFF}, so an overflow comes nibble*4096+4096 ticks after a restart. The current count reads back in status bits 31:16.
- R2: Clock register bits 1:0 select the tick period: 0 gives 8 cycles, 1 gives 32, 2 gives 128 and 3 gives 1024. Clock register bits 5:2 hold the reload nibble. Both fields read back at the same positions at address 1.
- R3: A write to address 2 carrying key 16'hC3A5 in bits 31:16 reloads the counter and clears the prescaler. The same write with any other key has no effect on the count.
- R4: Writes to the mode register (address 0) and to the clock register (address 1) take effect only with key 16'h5A3C in bits 31:16. A write with any other key leaves the register unchanged.
- R5: When mode bit 1 is set, an overflow produces a one-cycle high pulse on wd_rst_o in the cycle after the counting edge at which the count wraps.
- R6: When mode bit 2 is set, an overflow produces a one-cycle high pulse on wd_irq_o, with the same timing as the reset pulse.
- R7: When mode bit 3 is set, an overflow drives wd_ovf_n_o low for exactly 8 clock cycles, starting in the same cycle as the pulses.
- R8: The three actions are enabled independently. An action whose bit is clear stays inactive on an overflow.
- R9: While mode bit 0 (run) is clear, the counter holds its reload value and no overflow occurs.
- R10: Status bit 0 is set on overflow, stays set, and is cleared by a read of address 3. After an overflow the counter reloads and counts on without a restart.
- R11: After reset, all mode bits are 0, the clock register is 0, the count is 16'h0FFF, the flag is 0, both pulses are low and wd_ovf_n_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; a read of address 3 clears the flag |
| bus_addr | input | 2 | Register address: 0 mode, 1 clock, 2 restart, 3 status |
| bus_wdata | input | 32 | Write data; bits 31:16 carry the key |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| wd_rst_o | output | 1 | Internal reset pulse |
| wd_irq_o | output | 1 | Interrupt pulse |
| wd_ovf_n_o | output | 1 | Active-low stretched overflow output |

## Verification
The hardest event to reach is an overflow, and above all a second one that follows without a restart. Even with the fastest tick and a zero nibble, an overflow needs 32768 cycles. So the bench lets the counter run free through two full periods, changing only the action mix in between, and measures the cycle of each event against the restart edge. The slower dividers are never run to overflow. They are checked instead by reading the live count back through the status register a chosen number of cycles after a restart.

// File: rtl/wdog_pkg.sv
// Package: shared register addresses and the mode register layout.
// Assumes a 32-bit data bus with the access key in the upper half.
package wdog_pkg;
    localparam int DW    = 32;
    localparam int KEY_W = 16;

    typedef enum logic [1:0] {
        REG_MODE = 2'd0,
        REG_CLK  = 2'd1,
        REG_KICK = 2'd2,
        REG_STAT = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic ext_en;
        logic irq_en;
        logic rst_en;
        logic run_en;
    } mode_t;
endpackage

// File: rtl/wdog_prescaler.sv
// Prescaler: a free-running counter that yields a one-cycle tick every
// 2**DIVn cycles for the selected n. A clear restarts the phase at zero.
// Assumes that DIV3 is the largest log2 divider.
module wdog_prescaler #(
    parameter int DIV0 = 3,
    parameter int DIV1 = 5,
    parameter int DIV2 = 7,
    parameter int DIV3 = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic [1:0] sel,
    output logic       tick
);
    localparam int PRE_W = DIV3;
    localparam int LOGS [4] = '{DIV0, DIV1, DIV2, DIV3};

    logic [PRE_W-1:0] pre_cnt;
    logic [3:0]       hit;

    // Phase counter, cleared on reset, on a restart and while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) pre_cnt <= '0;
        else                 pre_cnt <= pre_cnt + 1'b1;
    end

    // One terminal-phase detector for each divider.
    for (genvar i = 0; i < 4; i++) begin : g_hit
        assign hit[i] = &pre_cnt[LOGS[i]-1:0];
    end

    assign tick = hit[sel];
endmodule

// File: rtl/wdog_counter.sv
// Down counter: it reloads to {nib, all ones} on a restart, while stopped
// and after it wraps, and decrements on each tick. It flags an overflow
// when a tick finds it at zero. Assumes the tick lasts one cycle.
module wdog_counter #(
    parameter int CNT_W = 16,
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             reload_req,
    input  logic             tick,
    input  logic [NIB_W-1:0] nib,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    localparam int LOW_W = CNT_W - NIB_W;

    logic [CNT_W-1:0] reload_val;

    assign reload_val = {nib, {LOW_W{1'b1}}};
    assign ovf        = run_en && tick && !reload_req && (cnt == '0);

    // Count register: reload, wrap or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)                            cnt <= {{NIB_W{1'b0}}, {LOW_W{1'b1}}};
        else if (!run_en || reload_req || ovf) cnt <= reload_val;
        else if (tick)                         cnt <= cnt - 1'b1;
    end

    // R1: a tick on a non-zero count lowers it by exactly one
    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && tick && !reload_req && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));
endmodule

// File: rtl/wdog_actions.sv
// Overflow actions: a registered reset pulse, a registered interrupt pulse
// and an active-low output held low for STRETCH cycles, each gated by its
// own enable. Assumes overflows are further apart than STRETCH cycles.
module wdog_actions
    import wdog_pkg::*;
#(
    parameter int STRETCH = 8
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ovf,
    input  mode_t mode,
    output logic  rst_pls,
    output logic  irq_pls,
    output logic  ext_n
);
    localparam int STR_W = $clog2(STRETCH + 1);

    logic [STR_W-1:0] str_cnt;

    // One-cycle pulses, registered from the overflow strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_pls <= 1'b0;
            irq_pls <= 1'b0;
        end else begin
            rst_pls <= ovf && mode.rst_en;
            irq_pls <= ovf && mode.irq_en;
        end
    end

    // Stretch counter for the external output.
    always_ff @(posedge clk) begin
        if (!rst_n)                   str_cnt <= '0;
        else if (ovf && mode.ext_en)  str_cnt <= STR_W'(STRETCH);
        else if (str_cnt != '0)       str_cnt <= str_cnt - 1'b1;
    end

    assign ext_n = (str_cnt == '0);

    // R5: the reset pulse lasts one cycle
    a_r5_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pls |=> !rst_pls);
    // R6: the interrupt pulse lasts one cycle
    a_r6_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pls |=> !irq_pls);
    // R7: an enabled overflow pulls the external output low
    a_r7_ext_start: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && mode.ext_en) |=> !ext_n);
    // R7: the output was low 8 cycles before it rises again
    a_r7_ext_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_n) |-> !$past(ext_n, 8));
endmodule

// File: rtl/wdog_regs.sv
// Register file: decodes bus writes and checks their keys, holds the mode,
// clock-select and nibble fields, raises the restart strobe and keeps the
// sticky overflow flag. Read data is combinational.
module wdog_regs
    import wdog_pkg::*;
#(
    parameter logic [KEY_W-1:0] CFG_KEY  = 16'h5A3C,
    parameter logic [KEY_W-1:0] KICK_KEY = 16'hC3A5,
    parameter int               CNT_W    = 16,
    parameter int               NIB_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [1:0]       bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    input  logic             ovf,
    input  logic [CNT_W-1:0] cnt,
    output mode_t            mode,
    output logic [1:0]       clk_sel,
    output logic [NIB_W-1:0] nib,
    output logic             kick,
    output logic [DW-1:0]    bus_rdata
);
    logic [KEY_W-1:0] key;
    logic             cfg_ok;
    logic             wr_mode;
    logic             wr_clk;
    logic             flag_q;

    assign key     = bus_wdata[DW-1 -: KEY_W];
    assign cfg_ok  = (key == CFG_KEY);
    assign wr_mode = bus_wr && (reg_sel_e'(bus_addr) == REG_MODE);
    assign wr_clk  = bus_wr && (reg_sel_e'(bus_addr) == REG_CLK);
    assign kick    = bus_wr && (reg_sel_e'(bus_addr) == REG_KICK) && (key == KICK_KEY);

    // Configuration registers, written only under a valid key.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode    <= '0;
            clk_sel <= '0;
            nib     <= '0;
        end else begin
            if (wr_mode && cfg_ok) mode <= mode_t'(bus_wdata[3:0]);
            if (wr_clk && cfg_ok) begin
                clk_sel <= bus_wdata[1:0];
                nib     <= bus_wdata[NIB_W+1:2];
            end
        end
    end

    // Sticky flag: set by an overflow, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n)                                         flag_q <= 1'b0;
        else if (ovf)                                       flag_q <= 1'b1;
        else if (bus_rd && reg_sel_e'(bus_addr) == REG_STAT) flag_q <= 1'b0;
    end

    // Read multiplexer.
    always_comb begin
        case (reg_sel_e'(bus_addr))
            REG_MODE: bus_rdata = {{(DW-4){1'b0}}, mode};
            REG_CLK:  bus_rdata = {{(DW-NIB_W-2){1'b0}}, nib, clk_sel};
            REG_STAT: bus_rdata = {cnt, {(DW-CNT_W-1){1'b0}}, flag_q};
            default:  bus_rdata = '0;
        endcase
    end

    // R4: a mode write with a bad key changes nothing
    a_r4_mode_key: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mode && !cfg_ok) |=> $stable(mode));
    // R4: a clock write with a bad key changes nothing
    a_r4_clk_key: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clk && !cfg_ok) |=> ($stable(clk_sel) && $stable(nib)));
    // R10: an overflow always leaves the flag set
    a_r10_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> flag_q);
endmodule

// File: rtl/wdog_keyed.sv
// Top: wires the register file, prescaler, down counter and overflow
// actions together. Assumes single-cycle bus strobes on the system clock.
module wdog_keyed
    import wdog_pkg::*;
#(
    parameter logic [15:0] CFG_KEY  = 16'h5A3C,
    parameter logic [15:0] KICK_KEY = 16'hC3A5,
    parameter int          CNT_W    = 16,
    parameter int          NIB_W    = 4,
    parameter int          STRETCH  = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        wd_rst_o,
    output logic        wd_irq_o,
    output logic        wd_ovf_n_o
);
    mode_t            mode;
    logic [1:0]       clk_sel;
    logic [NIB_W-1:0] nib;
    logic             kick;
    logic             tick;
    logic             ovf;
    logic [CNT_W-1:0] cnt;

    wdog_regs #(
        .CFG_KEY (CFG_KEY),
        .KICK_KEY(KICK_KEY),
        .CNT_W   (CNT_W),
        .NIB_W   (NIB_W)
    ) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .ovf      (ovf),
        .cnt      (cnt),
        .mode     (mode),
        .clk_sel  (clk_sel),
        .nib      (nib),
        .kick     (kick),
        .bus_rdata(bus_rdata)
    );

    wdog_prescaler i_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(kick || !mode.run_en),
        .sel  (clk_sel),
        .tick (tick)
    );

    wdog_counter #(
        .CNT_W(CNT_W),
        .NIB_W(NIB_W)
    ) i_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (mode.run_en),
        .reload_req(kick),
        .tick      (tick),
        .nib       (nib),
        .cnt       (cnt),
        .ovf       (ovf)
    );

    wdog_actions #(
        .STRETCH(STRETCH)
    ) i_act (
        .clk    (clk),
        .rst_n  (rst_n),
        .ovf    (ovf),
        .mode   (mode),
        .rst_pls(wd_rst_o),
        .irq_pls(wd_irq_o),
        .ext_n  (wd_ovf_n_o)
    );

    // R9: a stopped watchdog raises no pulse in the next cycle
    a_r9_stopped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !mode.run_en |=> (!wd_irq_o && !wd_rst_o));
endmodule

// File: tb/test_wdog_keyed.sv
module test_wdog_keyed;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wd_rst_o;
    logic        wd_irq_o;
    logic        wd_ovf_n_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    localparam logic [15:0] CK = 16'h5A3C;
    localparam logic [15:0] KK = 16'hC3A5;

    typedef struct packed {
        logic [1:0]  addr;
        logic [31:0] data;
        logic [31:0] exp_mode;
        logic [31:0] exp_clk;
    } vec_t;

    // R4: keyed and badly keyed writes, with the expected readback
    localparam vec_t VECS [6] = '{
        '{2'd0, {CK, 16'h000E}, 32'h0E, 32'h00},
        '{2'd0, {16'h1234, 16'h0001}, 32'h0E, 32'h00},
        '{2'd1, {CK, 16'h0016}, 32'h0E, 32'h16},
        '{2'd1, {16'h5A3B, 16'h0003}, 32'h0E, 32'h16},
        '{2'd1, {CK, 16'h0000}, 32'h0E, 32'h00},
        '{2'd0, {CK, 16'h0000}, 32'h00, 32'h00}
    };

    wdog_keyed i_wdog_keyed (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .wd_rst_o  (wd_rst_o),
        .wd_irq_o  (wd_irq_o),
        .wd_ovf_n_o(wd_ovf_n_o)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic watch(input int limit, output int t_hit, output int n_irq,
                         output int n_rst, output int n_ext);
        t_hit = -1; n_irq = 0; n_rst = 0; n_ext = 0;
        for (int i = 0; i < limit && t_hit < 0; i++) begin
            @(negedge clk);
            if (wd_irq_o || wd_rst_o || !wd_ovf_n_o) t_hit = cyc;
        end
        if (t_hit >= 0) begin
            for (int j = 0; j < 16; j++) begin
                n_irq += int'(wd_irq_o);
                n_rst += int'(wd_rst_o);
                n_ext += int'(!wd_ovf_n_o);
                @(negedge clk);
            end
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        wait (cyc > 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int t0, th, ni, nr, ne;
        int m_list [4] = '{100, 100, 1000, 2100};
        int d_list [4] = '{8, 32, 128, 1024};

        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R11: reset state
        bus_read(2'd0, rd); chk("R11 mode", rd, 32'h0);
        bus_read(2'd1, rd); chk("R11 clock", rd, 32'h0);
        bus_read(2'd3, rd); chk("R11 status", rd, 32'h0FFF_0000);
        chk("R11 irq", {31'b0, wd_irq_o}, 32'h0);
        chk("R11 rst", {31'b0, wd_rst_o}, 32'h0);
        chk("R11 ext", {31'b0, wd_ovf_n_o}, 32'h1);

        // R4: table of keyed writes
        for (int v = 0; v < 6; v++) begin
            bus_write(VECS[v].addr, VECS[v].data);
            bus_read(2'd0, rd); chk("R4 mode", rd, VECS[v].exp_mode);
            bus_read(2'd1, rd); chk("R4 clock", rd, VECS[v].exp_clk);
        end

        // R9: stopped counter holds its reload value with nibble 5
        bus_write(2'd1, {CK, 16'h0014});
        repeat (200) @(posedge clk);
        bus_read(2'd3, rd); chk("R9 held count", rd, 32'h5FFF_0000);

        // R2: each divider, checked by count readback after a restart
        bus_write(2'd0, {CK, 16'h0001});
        for (int k = 0; k < 4; k++) begin
            bus_write(2'd1, {CK, 16'(k)});
            bus_write(2'd2, {KK, 16'h0});
            repeat (m_list[k]) @(posedge clk);
            bus_read(2'd3, rd);
            chk("R2 divider", rd, {16'(4095 - m_list[k] / d_list[k]), 16'h0});
        end

        // R3: a badly keyed restart is ignored, a good one reloads
        bus_write(2'd1, {CK, 16'h0000});
        bus_write(2'd2, {KK, 16'h0});
        repeat (100) @(posedge clk);
        bus_write(2'd2, {16'hC3A4, 16'h0});
        repeat (50) @(posedge clk);
        bus_read(2'd3, rd); chk("R3 bad key restart", rd, 32'h0FED_0000);
        bus_write(2'd2, {KK, 16'h0});
        repeat (7) @(posedge clk);
        bus_read(2'd3, rd); chk("R3 restart reload", rd, 32'h0FFF_0000);

        // R1 R6 R8: first overflow with only the interrupt enabled
        bus_write(2'd0, {CK, 16'h0005});
        bus_write(2'd2, {KK, 16'h0});
        t0 = cyc;
        watch(40000, th, ni, nr, ne);
        chk("R1 overflow time", 32'(th - t0), 32'd32768);
        chk("R6 irq width", 32'(ni), 32'd1);
        chk("R8 rst off", 32'(nr), 32'd0);
        chk("R8 ext off", 32'(ne), 32'd0);

        // R10: sticky flag, cleared by the read
        bus_read(2'd3, rd); chk("R10 flag set", {31'b0, rd[0]}, 32'h1);
        bus_read(2'd3, rd); chk("R10 flag cleared", {31'b0, rd[0]}, 32'h0);

        // R5 R7 R8 R10: second overflow without a restart, reset and external
        bus_write(2'd0, {CK, 16'h000B});
        watch(40000, th, ni, nr, ne);
        chk("R10 free-run period", 32'(th - t0), 32'd65536);
        chk("R5 rst width", 32'(nr), 32'd1);
        chk("R7 ext low cycles", 32'(ne), 32'd8);
        chk("R8 irq off", 32'(ni), 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule